// File: doc/BRIEF.md
# AES-128 Round Key Expander

This block generates the eleven AES-128 round keys from a 128-bit cipher key, one key at a time. It runs beside an iterative cipher core. A load strobe captures the cipher key, which is round key 0. Each advance strobe then replaces the held key with the next round key, computed directly from the key currently held. No schedule is ever stored, so the storage is a single 128-bit key register, a round index and a round-constant register.

Each step takes the last 32-bit word of the held key and transforms it: a one-byte rotation, a substitution of each of its four bytes, and an XOR of the round constant into the top byte. The transformed word is then folded into the four words of the old key through a chain of XORs. The four byte substitutions are built as logic that computes the field inverse and then the affine map, so no memory is used.

Top module: `aes128_rkey_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `rnd_o` = 0 and `rkey_o` = 0.
- R2: A rising edge with `load_i` high makes `rkey_o` equal `key_i` and `rnd_o` equal 0 from that edge on. `load_i` takes priority over `step_i`.
- R3: A rising edge with `step_i` high, `load_i` low and `rnd_o` below 10 replaces `rkey_o` with the next round key and raises `rnd_o` by one.
- R4: Words are numbered 0 to 3, with word 0 in bits 127:96 and the first byte of each word in its top bits. New word 0 is old word 0 XOR the transformed word. New word i (i = 1..3) is old word i XOR new word i-1.
- R5: The transformed word is old word 3 rotated left by one byte (its top byte moves to the bottom), then each byte is substituted, then the round constant is XORed into the top byte.
- R6: The round constant used to produce round key r (r = 1..10) is, in hex, 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36 in that order.
- R7: The byte substitution is the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapped to 0, followed by the affine map b_i ^ b_(i+4) ^ b_(i+5) ^ b_(i+6) ^ b_(i+7) ^ c_i with c = 63 hex and indices taken mod 8.
- R8: `rnd_o` never exceeds 10. An advance while `rnd_o` is 10 changes neither `rnd_o` nor `rkey_o`.
- R9: An edge with neither strobe high leaves both outputs unchanged.
- R10: For the cipher key 2b7e151628aed2a6abf7158809cf4f3c, round key 10 is d014f9a8c9ee2589e13f0cc8b6630ca6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture `key_i` as round key 0 |
| key_i | input | 128 | Cipher key |
| step_i | input | 1 | Advance to the next round key |
| rkey_o | output | 128 | Current round key (registered) |
| rnd_o | output | 4 | Index of the current round key, 0 to 10 |

## Verification
Every result is registered, so each strobe's effect appears in the cycle after the rising edge that samples the strobe. This holds for loading, advancing, the saturated advance and reset. The bench changes inputs only at falling edges and samples the outputs at the next falling edge, half a period after the edge that updated them, and checks them there. Holding cases are checked over several idle edges. A sweep of 64 crafted keys exposes all 256 byte substitutions in round 1, and further keys are followed through all ten rounds against a model built on log and antilog tables.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;

  typedef logic [BYTE_W-1:0] kx_byte_t;
  typedef logic [WORD_W-1:0] kx_word_t;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic kx_byte_t gf_xtime(input kx_byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic kx_byte_t gf_mul(input kx_byte_t a, input kx_byte_t b);
    kx_byte_t acc;
    kx_byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // a^254 by square-and-multiply; zero stays zero
  function automatic kx_byte_t gf_inv(input kx_byte_t a);
    kx_byte_t r;
    logic [7:0] ex;
    ex = 8'hfe;
    r  = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gf_mul(r, r);
      if (ex[i]) r = gf_mul(r, a);
    end
    return r;
  endfunction
endpackage

// File: rtl/kx_sbox.sv
module kx_sbox
  import aes_kx_pkg::*;
(
  input  kx_byte_t din,
  output kx_byte_t dout
);
  kx_byte_t inv;

  always_comb begin
    inv  = gf_inv(din);
    dout = inv
         ^ {inv[6:0], inv[7]}
         ^ {inv[5:0], inv[7:6]}
         ^ {inv[4:0], inv[7:5]}
         ^ {inv[3:0], inv[7:4]}
         ^ 8'h63;
  end
endmodule

// File: rtl/kx_word_xform.sv
module kx_word_xform
  import aes_kx_pkg::*;
#(
  parameter int NBYTES = WORD_BYTES
) (
  input  logic [NBYTES*BYTE_W-1:0] w_in,
  input  kx_byte_t                 rcon,
  output logic [NBYTES*BYTE_W-1:0] w_out
);
  localparam int WW = NBYTES * BYTE_W;

  logic [WW-1:0] rotw;
  logic [WW-1:0] subw;

  assign rotw = {w_in[WW-BYTE_W-1:0], w_in[WW-1 -: BYTE_W]};

  for (genvar b = 0; b < NBYTES; b++) begin : g_sub
    kx_sbox u_sbox (
      .din  (rotw[b*BYTE_W +: BYTE_W]),
      .dout (subw[b*BYTE_W +: BYTE_W])
    );
  end

  assign w_out = subw ^ {rcon, {(WW-BYTE_W){1'b0}}};
endmodule

// File: rtl/kx_round.sv
module kx_round
  import aes_kx_pkg::*;
#(
  parameter int NWORDS = 4
) (
  input  logic [NWORDS*WORD_W-1:0] key_in,
  input  kx_word_t                 t_word,
  output logic [NWORDS*WORD_W-1:0] key_out
);
  localparam int KW = NWORDS * WORD_W;

  kx_word_t nw [NWORDS];

  for (genvar i = 0; i < NWORDS; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign nw[i] = key_in[KW-1 -: WORD_W] ^ t_word;
    end else begin : g_rest
      assign nw[i] = key_in[KW-1-i*WORD_W -: WORD_W] ^ nw[i-1];
    end
    assign key_out[KW-1-i*WORD_W -: WORD_W] = nw[i];
  end
endmodule

// File: rtl/aes128_rkey_gen.sv
module aes128_rkey_gen
  import aes_kx_pkg::*;
#(
  parameter int NWORDS  = 4,
  parameter int NROUNDS = 10,
  localparam int KW     = NWORDS * WORD_W,
  localparam int IDX_W  = $clog2(NROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [KW-1:0]    key_i,
  input  logic             step_i,
  output logic [KW-1:0]    rkey_o,
  output logic [IDX_W-1:0] rnd_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NROUNDS);

  logic [KW-1:0]    key_q;
  logic [IDX_W-1:0] idx_q;
  kx_byte_t         rcon_q;
  kx_word_t         t_word;
  logic [KW-1:0]    key_nxt;
  logic             adv;

  kx_word_xform #(.NBYTES(WORD_BYTES)) u_xform (
    .w_in  (key_q[WORD_W-1:0]),
    .rcon  (rcon_q),
    .w_out (t_word)
  );

  kx_round #(.NWORDS(NWORDS)) u_round (
    .key_in  (key_q),
    .t_word  (t_word),
    .key_out (key_nxt)
  );

  assign adv = step_i && (idx_q != LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= '0;
      idx_q  <= '0;
      rcon_q <= 8'h01;
    end else if (load_i) begin
      key_q  <= key_i;
      idx_q  <= '0;
      rcon_q <= 8'h01;
    end else if (adv) begin
      key_q  <= key_nxt;
      idx_q  <= idx_q + 1'b1;
      rcon_q <= gf_xtime(rcon_q);
    end
  end

  assign rkey_o = key_q;
  assign rnd_o  = idx_q;
endmodule

// File: rtl/aes128_rkey_gen_chk.sv
module aes128_rkey_gen_chk #(
  parameter int NWORDS  = 4,
  parameter int NROUNDS = 10,
  localparam int KW     = NWORDS * 32,
  localparam int IDX_W  = $clog2(NROUNDS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             load_i,
  input logic [KW-1:0]    key_i,
  input logic             step_i,
  input logic [KW-1:0]    rkey_o,
  input logic [IDX_W-1:0] rnd_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NROUNDS);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rnd_o == '0 && rkey_o == '0));

  a_r2_load_key: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (rnd_o == '0 && rkey_o == $past(key_i)));

  a_r3_step_index: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && rnd_o != LAST) |=> (rnd_o == IDX_W'($past(rnd_o) + 1'b1)));

  for (genvar i = 1; i < NWORDS; i++) begin : g_r4
    a_r4_word_chain: assert property (@(posedge clk) disable iff (rst)
      (step_i && !load_i && rnd_o != LAST) |=>
        ((rkey_o[KW-1-i*32 -: 32] ^ rkey_o[KW-1-(i-1)*32 -: 32]) == $past(rkey_o[KW-1-i*32 -: 32])));
  end

  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && rnd_o == LAST) |=> ($stable(rkey_o) && rnd_o == LAST));

  a_r8_index_range: assert property (@(posedge clk) disable iff (rst)
    rnd_o <= LAST);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> ($stable(rkey_o) && $stable(rnd_o)));
endmodule

bind aes128_rkey_gen aes128_rkey_gen_chk #(.NWORDS(NWORDS), .NROUNDS(NROUNDS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .load_i (load_i),
  .key_i  (key_i),
  .step_i (step_i),
  .rkey_o (rkey_o),
  .rnd_o  (rnd_o)
);

// File: tb/aes128_rkey_gen_test.sv
module aes128_rkey_gen_test;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic         step_i = 1'b0;
  logic [127:0] key_i = '0;
  logic [127:0] rkey_o;
  logic [3:0]   rnd_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] exp_t [256];
  int         log_t [256];
  logic [7:0] rc_t  [10];

  always #(CLK_P/2) clk = ~clk;

  aes128_rkey_gen uut (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .key_i  (key_i),
    .step_i (step_i),
    .rkey_o (rkey_o),
    .rnd_o  (rnd_o)
  );

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] s;
    logic [7:0] c;
    c   = 8'h63;
    inv = (x == 8'h00) ? 8'h00 : exp_t[(255 - log_t[x]) % 255];
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return s;
  endfunction

  function automatic logic [127:0] m_next(input logic [127:0] k, input int r);
    logic [31:0] w [4];
    logic [31:0] t;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    t = {m_sbox(w[3][23:16]) ^ rc_t[r-1], m_sbox(w[3][15:8]),
         m_sbox(w[3][7:0]), m_sbox(w[3][31:24])};
    w[0] = w[0] ^ t;
    for (int i = 1; i < 4; i++) w[i] = w[i] ^ w[i-1];
    return {w[0], w[1], w[2], w[3]};
  endfunction

  task automatic chk(input logic [127:0] act, input logic [127:0] expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic do_load(input logic [127:0] k);
    @(negedge clk);
    key_i  = k;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_step();
    @(negedge clk);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic run_key(input logic [127:0] k, input string tag);
    logic [127:0] prev;
    logic [127:0] expv;
    do_load(k);
    chk(rkey_o, k, {tag, " R2 load"});
    prev = k;
    for (int r = 1; r <= 10; r++) begin
      do_step();
      expv = m_next(prev, r);
      chk(rkey_o, expv, {tag, " R3 next key"});
      chk(128'(rnd_o), 128'(r), {tag, " R3 index"});
      chk(128'(rkey_o[95:64] ^ rkey_o[127:96]), 128'(prev[95:64]), {tag, " R4 chain"});
      prev = expv;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0]   e;
    logic [127:0] lk;
    logic [7:0]   b0;
    // R6: round constants
    rc_t = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
    // generator 3 tables for the R7 model
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = e;
      log_t[e] = i;
      e = e ^ ({e[6:0], 1'b0} ^ (e[7] ? 8'h1b : 8'h00));
    end
    exp_t[255] = 8'h01;
    log_t[0]   = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(rkey_o, '0, "R1 reset key");
    chk(128'(rnd_o), '0, "R1 reset index");

    repeat (3) @(negedge clk);
    chk(rkey_o, '0, "R9 idle key");
    chk(128'(rnd_o), '0, "R9 idle index");

    // zero key, round 1
    do_step();
    chk(rkey_o, 128'h62636363626363636263636362636363, "R5 R7 zero key round 1");
    chk(128'(rnd_o), 128'd1, "R3 zero key index");

    // reference key through all rounds
    run_key(128'h2b7e151628aed2a6abf7158809cf4f3c, "ref");
    chk(rkey_o, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R10 round 10");
    do_load(128'h2b7e151628aed2a6abf7158809cf4f3c);
    do_step();
    chk(rkey_o, 128'ha0fafe1788542cb123a339392a6c7605, "R5 R6 ref round 1");

    // saturation
    do_load(128'h2b7e151628aed2a6abf7158809cf4f3c);
    repeat (10) do_step();
    do_step();
    do_step();
    chk(rkey_o, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R8 saturated key");
    chk(128'(rnd_o), 128'd10, "R8 saturated index");
    repeat (2) @(negedge clk);
    chk(rkey_o, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R9 hold at 10");

    // load beats step, mid-sequence reload
    @(negedge clk);
    key_i  = 128'h00112233445566778899aabbccddeeff;
    load_i = 1'b1;
    step_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    step_i = 1'b0;
    chk(rkey_o, 128'h00112233445566778899aabbccddeeff, "R2 load priority key");
    chk(128'(rnd_o), '0, "R2 load priority index");
    repeat (3) do_step();
    do_load(128'hffeeddccbbaa99887766554433221100);
    chk(128'(rnd_o), '0, "R2 reload index");
    chk(rkey_o, 128'hffeeddccbbaa99887766554433221100, "R2 reload key");

    // zero key through all rounds (R6 constants in every round)
    run_key('0, "zero R6");

    // R7 sweep: every byte value passes through the substitution
    for (int b = 0; b < 64; b++) begin
      b0 = 8'(4*b);
      lk = {96'h0, b0, b0 + 8'd1, b0 + 8'd2, b0 + 8'd3};
      do_load(lk);
      do_step();
      chk(128'(rkey_o[127:96]),
          128'({m_sbox(b0 + 8'd1) ^ 8'h01, m_sbox(b0 + 8'd2), m_sbox(b0 + 8'd3), m_sbox(b0)}),
          "R7 sbox sweep");
      if (b == 0) chk(128'(rkey_o[127:96]), 128'h7d777b63, "R7 known substitutions");
    end

    // pseudo-random keys through all rounds
    lk = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    for (int n = 0; n < 8; n++) begin
      run_key(lk, "sweep R3");
      lk = {lk[126:0], lk[127] ^ lk[125] ^ lk[100] ^ lk[98]} ^ {lk[63:0], lk[127:64]};
    end

    done = 1'b1;
    finish_run();
  end
endmodule